// File: doc/BRIEF.md
# Path-Matched Trace Cache

This block sits beside the instruction cache in a wide fetch front end. Each line stores a dynamic trace: up to `N_INSTR` instructions covering up to `M_BLK` basic blocks. A trace is identified by its start address and by the directions taken at its inner conditional branches, of which there are at most `M_BLK-1`. Fetch presents an address and the predicted directions for those branches. One cycle later the block returns a full trace, or the longest leading part of a trace whose path agrees with the prediction, or a miss. A miss tells fetch to use the instruction cache for that cycle.

Each set holds `WAYS` lines. Several traces that start at the same address but follow different paths can therefore live side by side. For each inner branch, a line records the instruction count at the end of that branch's block and the address on the side the trace did not follow. For its final branch, the line records both the fall-through and the taken address. A separate predicted direction for that final branch picks between them. A fill port writes finished traces. It replaces a line that has the same identity, otherwise a free way, otherwise a tree pseudo-LRU victim.

Top module: `trace_cache`

## Requirements
- R1: After reset, every line is invalid and every output is zero. The first lookup then misses.
- R2: `o_valid` is high in exactly the cycle after a cycle with `lk_en` high, and low otherwise. Results appear with one cycle of latency. When `o_valid` is low, `o_hit`, `o_miss`, `o_full`, `o_count` and `o_next` are zero.
- R3: Full hit. A valid line has a start address equal to `lk_addr`, and `lk_pred[k]` equals the stored direction for every k below the line's branch count (bit k = 1 means taken). The block then gives `o_hit=1`, `o_full=1` and `o_count` equal to the trace length. `o_next` is the stored taken address if `lk_last_taken=1` and the fall-through address otherwise.
- R4: A stored direction bit, or a prediction bit, at a position at or above the line's branch count has no effect on matching.
- R5: Partial hit. If the lowest disagreeing position is k, the block gives `o_hit=1` and `o_full=0`. `o_count` is the line's block-end count for branch k, and `o_next` is its stored alternate address for branch k.
- R6: Miss. If no valid line in the set has an equal start address, the block gives `o_miss=1`, `o_hit=0`, `o_count=0` and `o_next=0`. `o_hit` and `o_miss` never both rise.
- R7: Among matching ways, a full match wins over any partial match. A partial match that agrees on more leading branches wins over a shorter one. On a tie, the lowest way wins.
- R8: A fill whose address, branch count and used direction bits equal those of a valid line in its set overwrites that line in place.
- R9: Any other fill goes to the lowest invalid way. If no way is invalid, it goes to the tree pseudo-LRU victim. Bit 0 of the tree is the root. Each bit points toward the child holding the victim (0 = lower half), and its children are heap-numbered. A hit or a fill makes every tree bit on its way's path point away from that way. A hit and a fill in one set in one cycle apply the hit first. The victim is chosen from the tree as it stood before that cycle.
- R10: A lookup and a fill in the same cycle to the same set give a lookup result computed from the contents before the fill.
- R11: Instruction lanes at or above `o_count` read as zero. Lane i is bits [32i+31:32i].
- R12: The set index is `lk_addr[IDX_W+1:2]` (bits 4..2 by default). Traces in different sets never evict or affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Fetch address |
| lk_pred | input | M_BLK-1 | Predicted directions of inner branches, bit k = branch k |
| lk_last_taken | input | 1 | Predicted direction of the trace's final branch |
| fl_en | input | 1 | Fill request |
| fl_addr | input | ADDR_W | Trace start address |
| fl_nbr | input | clog2(M_BLK) | Number of inner branches in the trace |
| fl_flags | input | M_BLK-1 | Recorded inner branch directions |
| fl_bend | input | (M_BLK-1)*CNT_W | Instruction count at the end of each inner branch's block |
| fl_alt | input | (M_BLK-1)*ADDR_W | Address of the side not followed at each inner branch |
| fl_len | input | CNT_W | Trace length in instructions |
| fl_ft | input | ADDR_W | Fall-through address after the final branch |
| fl_tgt | input | ADDR_W | Taken address after the final branch |
| fl_instr | input | N_INSTR*INSTR_W | Trace instructions, lane 0 first |
| o_valid | output | 1 | Lookup result present |
| o_hit | output | 1 | Full or partial hit |
| o_miss | output | 1 | No trace; fetch from instruction cache |
| o_full | output | 1 | Whole trace matched |
| o_count | output | CNT_W | Number of valid instruction lanes |
| o_next | output | ADDR_W | Next fetch address |
| o_instr | output | N_INSTR*INSTR_W | Delivered instructions, unused lanes zero |

## Verification
A wrong tag, direction comparison or way choice shows at the ports in the cycle after the lookup, as a wrong count, next address or lane content. A corrupted pseudo-LRU tree or a bad identity probe does not show at once. It surfaces only when a later fill evicts the wrong line and a subsequent lookup then hits or misses unexpectedly, possibly many cycles later. The bench's reference model therefore tracks every line and tree bit, and it repeatedly fills full sets so that such errors are exposed.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    LK_IDLE    = 2'd0,
    LK_MISS    = 2'd1,
    LK_PARTIAL = 2'd2,
    LK_FULL    = 2'd3
  } tc_outcome_e;
endpackage

// File: rtl/tc_way_match.sv
module tc_way_match #(
  parameter int ADDR_W = 32,
  parameter int M_BLK  = 3,
  parameter int NB     = M_BLK - 1,
  parameter int NBR_W  = 2,
  parameter int CNT_W  = 5,
  parameter int SC_W   = 2
) (
  input  logic                         v,
  input  logic [ADDR_W-1:0]            tag,
  input  logic [NBR_W-1:0]             nbr,
  input  logic [NB-1:0]                flags,
  input  logic [NB-1:0][CNT_W-1:0]     bend,
  input  logic [NB-1:0][ADDR_W-1:0]    alt,
  input  logic [CNT_W-1:0]             len,
  input  logic [ADDR_W-1:0]            ft,
  input  logic [ADDR_W-1:0]            tgt,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [NB-1:0]                pred,
  input  logic                         last,
  output logic                         tag_hit,
  output logic [SC_W-1:0]              score,
  output logic [CNT_W-1:0]             count,
  output logic [ADDR_W-1:0]            next
);
  logic found;

  always_comb begin
    tag_hit = v && (tag == addr);
    found   = 1'b0;
    score   = SC_W'(M_BLK);
    count   = len;
    next    = last ? tgt : ft;
    // scan downward so the lowest disagreeing branch is kept
    for (int k = NB - 1; k >= 0; k--) begin
      if ((k < int'(nbr)) && (flags[k] != pred[k])) begin
        found = 1'b1;
        score = SC_W'(k);
        count = bend[k];
        next  = alt[k];
      end
    end
  end
endmodule

// File: rtl/tc_pick.sv
module tc_pick
  import tc_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int M_BLK = 3,
  parameter int SC_W  = 2,
  parameter int WAY_W = 2
) (
  input  logic                        lk_en,
  input  logic [WAYS-1:0]             tag_hit,
  input  logic [WAYS-1:0][SC_W-1:0]   score,
  output logic [WAY_W-1:0]            sel,
  output tc_outcome_e                 outcome
);
  logic            any;
  logic [SC_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    best = '0;
    sel  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (tag_hit[w] && (!any || (score[w] > best))) begin
        any  = 1'b1;
        best = score[w];
        sel  = WAY_W'(w);
      end
    end
    if (!lk_en)                           outcome = LK_IDLE;
    else if (!any)                        outcome = LK_MISS;
    else if (best == SC_W'(M_BLK))        outcome = LK_FULL;
    else                                  outcome = LK_PARTIAL;
  end
endmodule

// File: rtl/tc_plru.sv
module tc_plru #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int WAY_W = $clog2(WAYS),
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_en,
  input  logic [IDX_W-1:0] hit_set,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim
);
  localparam int TB = WAYS - 1;

  logic [TB-1:0] tree   [SETS];
  logic [TB-1:0] tree_d [SETS];

  function automatic logic [TB-1:0] touch(input logic [TB-1:0] t, input logic [WAY_W-1:0] w);
    logic [TB-1:0] r;
    int node;
    r = t;
    node = 1;
    for (int l = 0; l < WAY_W; l++) begin
      r[node-1] = ~w[WAY_W-1-l];
      node = node * 2 + int'(w[WAY_W-1-l]);
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] pick(input logic [TB-1:0] t);
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++) node = node * 2 + int'(t[node-1]);
    return WAY_W'(node - WAYS);
  endfunction

  assign victim = pick(tree[fill_set]);

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      tree_d[s] = tree[s];
      if (hit_en && (hit_set == IDX_W'(s)))   tree_d[s] = touch(tree_d[s], hit_way);
      if (fill_en && (fill_set == IDX_W'(s))) tree_d[s] = touch(tree_d[s], fill_way);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst) tree[s] <= '0;
      else     tree[s] <= tree_d[s];
    end
  end
endmodule

// File: rtl/tc_line_ram.sv
module tc_line_ram #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int WIDTH = 512,
  parameter int WAY_W = $clog2(WAYS),
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic                         clk,
  input  logic                         we,
  input  logic [WAY_W-1:0]             wway,
  input  logic [IDX_W-1:0]             wset,
  input  logic [WIDTH-1:0]             wdata,
  input  logic [IDX_W-1:0]             rset,
  output logic [WAYS-1:0][WIDTH-1:0]   rdata
);
  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [WIDTH-1:0] mem [SETS];
    always_ff @(posedge clk) begin
      if (we && (wway == WAY_W'(w))) mem[wset] <= wdata;
      rdata[w] <= mem[rset];
    end
  end
endmodule

// File: rtl/trace_cache.sv
module trace_cache
  import tc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int N_INSTR = 16,
  parameter int M_BLK   = 3,
  parameter int WAYS    = 4,
  parameter int SETS    = 8,
  localparam int NB     = M_BLK - 1,
  localparam int NBR_W  = $clog2(M_BLK),
  localparam int CNT_W  = $clog2(N_INSTR + 1),
  localparam int LINE_W = N_INSTR * INSTR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_en,
  input  logic [ADDR_W-1:0]       lk_addr,
  input  logic [NB-1:0]           lk_pred,
  input  logic                    lk_last_taken,
  input  logic                    fl_en,
  input  logic [ADDR_W-1:0]       fl_addr,
  input  logic [NBR_W-1:0]        fl_nbr,
  input  logic [NB-1:0]           fl_flags,
  input  logic [NB*CNT_W-1:0]     fl_bend,
  input  logic [NB*ADDR_W-1:0]    fl_alt,
  input  logic [CNT_W-1:0]        fl_len,
  input  logic [ADDR_W-1:0]       fl_ft,
  input  logic [ADDR_W-1:0]       fl_tgt,
  input  logic [LINE_W-1:0]       fl_instr,
  output logic                    o_valid,
  output logic                    o_hit,
  output logic                    o_miss,
  output logic                    o_full,
  output logic [CNT_W-1:0]        o_count,
  output logic [ADDR_W-1:0]       o_next,
  output logic [LINE_W-1:0]       o_instr
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int SC_W  = $clog2(M_BLK + 1);

  // line metadata, kept in registers so every way compares in parallel
  logic [WAYS-1:0]              m_valid [SETS];
  logic [ADDR_W-1:0]            m_tag   [SETS][WAYS];
  logic [NBR_W-1:0]             m_nbr   [SETS][WAYS];
  logic [NB-1:0]                m_flags [SETS][WAYS];
  logic [NB-1:0][CNT_W-1:0]     m_bend  [SETS][WAYS];
  logic [NB-1:0][ADDR_W-1:0]    m_alt   [SETS][WAYS];
  logic [CNT_W-1:0]             m_len   [SETS][WAYS];
  logic [ADDR_W-1:0]            m_ft    [SETS][WAYS];
  logic [ADDR_W-1:0]            m_tgt   [SETS][WAYS];

  logic [IDX_W-1:0] lk_set, fl_set;
  assign lk_set = lk_addr[IDX_W+1:2];
  assign fl_set = fl_addr[IDX_W+1:2];

  logic [WAYS-1:0]              w_hit;
  logic [WAYS-1:0][SC_W-1:0]    w_score;
  logic [WAYS-1:0][CNT_W-1:0]   w_count;
  logic [WAYS-1:0][ADDR_W-1:0]  w_next;
  logic [WAYS-1:0]              w_same;   // fill identity probe

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tc_way_match #(
      .ADDR_W(ADDR_W), .M_BLK(M_BLK), .NB(NB), .NBR_W(NBR_W),
      .CNT_W(CNT_W), .SC_W(SC_W)
    ) u_match (
      .v      (m_valid[lk_set][w]),
      .tag    (m_tag[lk_set][w]),
      .nbr    (m_nbr[lk_set][w]),
      .flags  (m_flags[lk_set][w]),
      .bend   (m_bend[lk_set][w]),
      .alt    (m_alt[lk_set][w]),
      .len    (m_len[lk_set][w]),
      .ft     (m_ft[lk_set][w]),
      .tgt    (m_tgt[lk_set][w]),
      .addr   (lk_addr),
      .pred   (lk_pred),
      .last   (lk_last_taken),
      .tag_hit(w_hit[w]),
      .score  (w_score[w]),
      .count  (w_count[w]),
      .next   (w_next[w])
    );

    always_comb begin
      w_same[w] = m_valid[fl_set][w] && (m_tag[fl_set][w] == fl_addr) &&
                  (m_nbr[fl_set][w] == fl_nbr);
      for (int k = 0; k < NB; k++)
        if ((k < int'(fl_nbr)) && (m_flags[fl_set][w][k] != fl_flags[k])) w_same[w] = 1'b0;
    end
  end

  logic [WAY_W-1:0] sel;
  tc_outcome_e      outcome;

  tc_pick #(.WAYS(WAYS), .M_BLK(M_BLK), .SC_W(SC_W), .WAY_W(WAY_W)) u_pick (
    .lk_en  (lk_en),
    .tag_hit(w_hit),
    .score  (w_score),
    .sel    (sel),
    .outcome(outcome)
  );

  logic lk_found;
  assign lk_found = (outcome == LK_FULL) || (outcome == LK_PARTIAL);

  // fill way: same identity, else lowest free way, else tree victim
  logic [WAY_W-1:0] victim, fl_way;
  always_comb begin
    logic got;
    got    = 1'b0;
    fl_way = victim;
    for (int w = 0; w < WAYS; w++)
      if (!got && w_same[w]) begin got = 1'b1; fl_way = WAY_W'(w); end
    for (int w = 0; w < WAYS; w++)
      if (!got && !m_valid[fl_set][w]) begin got = 1'b1; fl_way = WAY_W'(w); end
  end

  tc_plru #(.WAYS(WAYS), .SETS(SETS)) u_plru (
    .clk     (clk),
    .rst     (rst),
    .hit_en  (lk_found),
    .hit_set (lk_set),
    .hit_way (sel),
    .fill_en (fl_en),
    .fill_set(fl_set),
    .fill_way(fl_way),
    .victim  (victim)
  );

  logic [WAYS-1:0][LINE_W-1:0] rd;
  tc_line_ram #(.WAYS(WAYS), .SETS(SETS), .WIDTH(LINE_W)) u_ram (
    .clk  (clk),
    .we   (fl_en),
    .wway (fl_way),
    .wset (fl_set),
    .wdata(fl_instr),
    .rset (lk_set),
    .rdata(rd)
  );

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst) m_valid[s] <= '0;
      else if (fl_en && (fl_set == IDX_W'(s))) m_valid[s][fl_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_en) begin
      m_tag[fl_set][fl_way]   <= fl_addr;
      m_nbr[fl_set][fl_way]   <= fl_nbr;
      m_flags[fl_set][fl_way] <= fl_flags;
      m_bend[fl_set][fl_way]  <= fl_bend;
      m_alt[fl_set][fl_way]   <= fl_alt;
      m_len[fl_set][fl_way]   <= fl_len;
      m_ft[fl_set][fl_way]    <= fl_ft;
      m_tgt[fl_set][fl_way]   <= fl_tgt;
    end
  end

  logic [WAY_W-1:0] sel_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_hit   <= 1'b0;
      o_miss  <= 1'b0;
      o_full  <= 1'b0;
      o_count <= '0;
      o_next  <= '0;
      sel_q   <= '0;
    end else begin
      o_valid <= lk_en;
      o_hit   <= lk_found;
      o_miss  <= (outcome == LK_MISS);
      o_full  <= (outcome == LK_FULL);
      o_count <= lk_found ? w_count[sel] : '0;
      o_next  <= lk_found ? w_next[sel]  : '0;
      sel_q   <= sel;
    end
  end

  always_comb begin
    for (int l = 0; l < N_INSTR; l++)
      o_instr[l*INSTR_W +: INSTR_W] = (l < int'(o_count)) ? rd[sel_q][l*INSTR_W +: INSTR_W]
                                                          : '0;
  end
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int CNT_W   = 5,
  parameter int N_INSTR = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_en,
  input logic             o_valid,
  input logic             o_hit,
  input logic             o_miss,
  input logic             o_full,
  input logic [CNT_W-1:0] o_count
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_en |=> o_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !lk_en |=> !o_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> !o_hit && !o_miss && !o_full && (o_count == '0));
  a_r6_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (o_hit != o_miss));
  a_r6_miss_empty: assert property (@(posedge clk) disable iff (rst)
    o_miss |-> (o_count == '0));
  a_r3_full_is_hit: assert property (@(posedge clk) disable iff (rst)
    o_full |-> o_hit);
  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    o_count <= CNT_W'(N_INSTR));
endmodule

bind trace_cache tc_checker #(.CNT_W(CNT_W), .N_INSTR(N_INSTR)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .lk_en  (lk_en),
  .o_valid(o_valid),
  .o_hit  (o_hit),
  .o_miss (o_miss),
  .o_full (o_full),
  .o_count(o_count)
);

// File: tb/trace_cache_test.sv
module trace_cache_test;
  localparam int AW = 32, IW = 32, N = 16, M = 3, NB = 2, WAYS = 4, SETS = 8, CW = 5;

  typedef struct {
    logic [31:0] addr;
    int          nbr;
    bit          f0, f1;
    int          be0, be1, len;
    logic [31:0] a0, a1, ft, tgt;
    int          seed;
  } frec_t;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic lk_en = 0, lk_last_taken = 0, fl_en = 0;
  logic [AW-1:0] lk_addr = '0, fl_addr = '0, fl_ft = '0, fl_tgt = '0;
  logic [NB-1:0] lk_pred = '0, fl_flags = '0;
  logic [1:0] fl_nbr = '0;
  logic [NB*CW-1:0] fl_bend = '0;
  logic [NB*AW-1:0] fl_alt = '0;
  logic [CW-1:0] fl_len = '0;
  logic [N*IW-1:0] fl_instr = '0;
  logic o_valid, o_hit, o_miss, o_full;
  logic [CW-1:0] o_count;
  logic [AW-1:0] o_next;
  logic [N*IW-1:0] o_instr;

  trace_cache uut (.*);

  // reference state
  bit          bm_v   [SETS][WAYS];
  logic [31:0] bm_tag [SETS][WAYS];
  frec_t       bm_ln  [SETS][WAYS];
  bit          bm_tr  [SETS][3];

  int nchecks = 0, nerr = 0;
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] word(int seed, int lane);
    return seed * 32'h0100_0193 + lane * 32'h0001_0001 + 1;
  endfunction

  function automatic logic [31:0] nxt_rng();
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    return rng;
  endfunction

  // tree bits: 0 root, 1 lower pair, 2 upper pair; a bit points at the victim side
  function automatic int tr_victim(int s);
    int node = 1;
    for (int l = 0; l < 2; l++) node = node * 2 + int'(bm_tr[s][node-1]);
    return node - WAYS;
  endfunction

  function automatic void tr_touch(int s, int w);
    int node = 1;
    for (int l = 0; l < 2; l++) begin
      bit b = bit'((w >> (1 - l)) & 1);
      bm_tr[s][node-1] = ~b;
      node = node * 2 + int'(b);
    end
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
  endtask

  task automatic step(bit le, logic [31:0] la, bit p0, bit p1, bit lt,
                      bit fe, frec_t f, string tag);
    int ls, fs, best, bw, ex_cnt, fw;
    bit any, ex_hit, ex_miss, ex_full;
    logic [31:0] ex_next;
    int ex_seed;
    bit bad;
    lk_en = le; lk_addr = la; lk_pred = {p1, p0}; lk_last_taken = lt;
    fl_en = fe; fl_addr = f.addr; fl_nbr = 2'(f.nbr); fl_flags = {f.f1, f.f0};
    fl_bend = {5'(f.be1), 5'(f.be0)}; fl_alt = {f.a1, f.a0}; fl_len = 5'(f.len);
    fl_ft = f.ft; fl_tgt = f.tgt;
    for (int l = 0; l < N; l++) fl_instr[l*IW +: IW] = word(f.seed, l);

    ls = int'(la[4:2]); fs = int'(f.addr[4:2]);
    any = 0; best = 0; bw = 0; ex_cnt = 0; ex_next = '0; ex_seed = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (bm_v[ls][w] && bm_tag[ls][w] == la) begin
        int sc = 3, cnt = bm_ln[ls][w].len;
        logic [31:0] nx = lt ? bm_ln[ls][w].tgt : bm_ln[ls][w].ft;
        if (bm_ln[ls][w].nbr > 1 && bm_ln[ls][w].f1 != p1) begin
          sc = 1; cnt = bm_ln[ls][w].be1; nx = bm_ln[ls][w].a1;
        end
        if (bm_ln[ls][w].nbr > 0 && bm_ln[ls][w].f0 != p0) begin
          sc = 0; cnt = bm_ln[ls][w].be0; nx = bm_ln[ls][w].a0;
        end
        if (!any || sc > best) begin
          any = 1; best = sc; bw = w; ex_cnt = cnt; ex_next = nx; ex_seed = bm_ln[ls][w].seed;
        end
      end
    end
    ex_hit = le && any; ex_miss = le && !any; ex_full = ex_hit && best == 3;
    if (!ex_hit) begin ex_cnt = 0; ex_next = '0; end

    fw = -1;
    if (fe) begin
      for (int w = 0; w < WAYS; w++)
        if (fw < 0 && bm_v[fs][w] && bm_tag[fs][w] == f.addr && bm_ln[fs][w].nbr == f.nbr &&
            (f.nbr < 1 || bm_ln[fs][w].f0 == f.f0) && (f.nbr < 2 || bm_ln[fs][w].f1 == f.f1))
          fw = w;
      for (int w = 0; w < WAYS; w++) if (fw < 0 && !bm_v[fs][w]) fw = w;
      if (fw < 0) fw = tr_victim(fs);
    end
    if (ex_hit) tr_touch(ls, bw);
    if (fe) begin
      tr_touch(fs, fw);
      bm_v[fs][fw] = 1; bm_tag[fs][fw] = f.addr; bm_ln[fs][fw] = f;
    end

    @(posedge clk); @(negedge clk);
    nchecks++;
    bad = (o_valid !== le) || (o_hit !== ex_hit) || (o_miss !== ex_miss) ||
          (o_full !== ex_full) || (o_count !== 5'(ex_cnt)) || (o_next !== ex_next);
    for (int l = 0; l < N; l++)
      if (o_instr[l*IW +: IW] !== ((l < ex_cnt) ? word(ex_seed, l) : 32'h0)) bad = 1;
    if (bad) begin
      nerr++;
      $display("FAIL %s: got v=%b h=%b m=%b f=%b cnt=%0d next=%h lane0=%h, expected v=%b h=%b m=%b f=%b cnt=%0d next=%h lane0=%h",
               tag, o_valid, o_hit, o_miss, o_full, o_count, o_next, o_instr[IW-1:0],
               le, ex_hit, ex_miss, ex_full, ex_cnt, ex_next,
               (ex_cnt > 0) ? word(ex_seed, 0) : 32'h0);
    end
  endtask

  function automatic frec_t mk(logic [31:0] a, int nbr, bit f0, bit f1, int be0, int be1,
                               int len, logic [31:0] a0, logic [31:0] a1,
                               logic [31:0] ft, logic [31:0] tgt, int seed);
    frec_t r;
    r.addr = a; r.nbr = nbr; r.f0 = f0; r.f1 = f1; r.be0 = be0; r.be1 = be1; r.len = len;
    r.a0 = a0; r.a1 = a1; r.ft = ft; r.tgt = tgt; r.seed = seed;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    frec_t z, t1, t2, t3, t4, t5, tb;
    z  = mk(32'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    t1 = mk(32'h100, 2, 1, 0, 4, 9, 14, 32'h200, 32'h300, 32'h400, 32'h500, 11);
    t2 = mk(32'h100, 1, 0, 1, 6, 0, 11, 32'h600, 32'h0,   32'h700, 32'h710, 22);
    t3 = mk(32'h100, 2, 1, 1, 3, 8, 12, 32'h800, 32'h900, 32'hA00, 32'hA10, 33);
    t4 = mk(32'h100, 2, 0, 0, 2, 5, 7,  32'hB00, 32'hB10, 32'hB20, 32'hB30, 44);
    t5 = mk(32'h120, 0, 0, 0, 0, 0, 16, 32'h0,   32'h0,   32'hC00, 32'hC10, 55);
    tb = mk(32'h104, 1, 1, 0, 5, 0, 10, 32'hD00, 32'h0,   32'hD10, 32'hD20, 66);

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    nchecks++;
    if (o_valid !== 0 || o_hit !== 0 || o_miss !== 0 || o_count !== 0 || o_next !== 0 || o_instr !== '0) begin
      nerr++; $display("FAIL R1 reset outputs: got v=%b cnt=%0d, expected all zero", o_valid, o_count);
    end
    step(0, 0, 0, 0, 0, 0, z, "R2 idle");
    step(1, 32'h100, 1, 0, 1, 0, z, "R1 cold miss");
    step(1, 32'h100, 1, 0, 1, 1, t1, "R10 fill same set sees old");
    step(1, 32'h100, 1, 0, 1, 0, z, "R3 full hit taken");
    step(1, 32'h100, 1, 0, 0, 0, z, "R3 full hit fallthrough");
    step(1, 32'h100, 1, 1, 0, 0, z, "R5 partial at branch 1");
    step(1, 32'h100, 0, 0, 0, 0, z, "R5 partial at branch 0");
    step(0, 0, 0, 0, 0, 1, t2, "R2 fill only");
    step(1, 32'h100, 0, 0, 0, 0, z, "R7 full beats partial");
    step(1, 32'h100, 0, 1, 1, 0, z, "R4 flag above count ignored");
    step(1, 32'h100, 1, 1, 0, 0, z, "R7 longest partial wins");
    step(1, 32'h100, 1, 0, 1, 1, t3, "R10 R9 hit and fill same set");
    step(1, 32'h100, 1, 1, 1, 0, z, "R7 path associativity");
    t1.len = 13; t1.seed = 77;
    step(0, 0, 0, 0, 0, 1, t1, "R8 refill identity");
    step(1, 32'h100, 1, 0, 1, 0, z, "R8 overwritten in place");
    step(1, 32'h104, 1, 0, 0, 1, t4, "R12 fill other lookup");
    step(1, 32'h100, 0, 0, 1, 0, z, "R9 fourth way used");
    step(0, 0, 0, 0, 0, 1, t5, "R9 victim fill");
    for (int p = 0; p < 4; p++)
      step(1, 32'h100, bit'(p & 1), bit'(p >> 1), 0, 0, z, "R9 after eviction");
    step(1, 32'h120, 0, 0, 1, 0, z, "R9 new trace hits");
    step(0, 0, 0, 0, 0, 1, tb, "R12 other set fill");
    step(1, 32'h104, 1, 1, 0, 0, z, "R12 other set hit");
    step(1, 32'h108, 1, 1, 0, 0, z, "R6 miss other set");
    step(1, 32'h100, 1, 1, 1, 0, z, "R12 set 0 unaffected");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r1, r2;
      frec_t f;
      int be0, be1;
      r1 = nxt_rng(); r2 = nxt_rng();
      be0 = 1 + int'(r2[1:0]); be1 = be0 + 1 + int'(r2[3:2]);
      f = mk(32'h1000 + 32'(r2[6:4] % 5) * 32'h20 + 32'(r2[7]) * 4, int'(r2[9:8] % 3),
             r2[10], r2[11], be0, be1, be1 + 1 + int'(r2[14:12] % 5),
             32'h2000 + 32'(i), 32'h3000 + 32'(i), 32'h4000 + 32'(i), 32'h5000 + 32'(i), 100 + i);
      step(r1[0], 32'h1000 + 32'(r1[4:2] % 5) * 32'h20 + 32'(r1[5]) * 4,
           r1[6], r1[7], r1[8], r1[9] & r1[10], f, "R7 R9 R10 random mix");
    end
    summary();
    $finish;
  end
endmodule